// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Lane Array

This block is a SIMD execution datapath. It updates an accumulator vector from two signed source vectors. Each lane doubles the product of its two source elements and adds it to, or subtracts it from, the accumulator element placed in the upper half of a double-width value. A rounding constant is added and the high half is kept. The lane result is then clamped to the signed lane range, and any clamp raises a sticky saturation flag.

Lanes are 16 or 32 bits wide, and the vector is 64 or 128 bits. There are three forms:
- vector: lane-wise operands.
- by-element: every lane uses one indexed element of the second source.
- scalar: lane 0 only.

Illegal combinations raise an undefined-operation flag and return the accumulator unchanged. Operations enter through a valid/ready handshake. Each result leaves from a single registered output stage.

Top module: `rdmac_top`

## Requirements
- R1: For an n-bit lane, the result is ((acc·2^n) + 2·a·b + 2^(n-1)) shifted arithmetically right by n. acc, a and b are signed, and no intermediate wraps.
- R2: With `subSel`=1 the doubled product is subtracted instead of added. Everything else in the computation is unchanged.
- R3: A shifted value above 2^(n-1)-1 gives that maximum in the lane and sets the saturation flag.
- R4: A shifted value below -2^(n-1) gives that minimum in the lane and sets the saturation flag.
- R5: `elemSize` 1 selects 16-bit lanes and 2 selects 32-bit lanes. Codes 0 and 3 raise `undefOut`, return `accIn` unchanged and leave the saturation flag untouched.
- R6: With `featEn`=0 the operation raises `undefOut`, returns `accIn` unchanged and leaves the saturation flag untouched.
- R7: `wideSel`=1 processes all 128 bits (8 or 4 lanes). `wideSel`=0 processes bits 63:0 (4 or 2 lanes) and writes zero to bits 127:64.
- R8: `formSel`=1 is the by-element form: every lane uses the element of `srcB` at position `laneIdx`. A `laneIdx` at or above the lane count of the chosen width raises `undefOut`. `formSel`=0 is the lane-wise vector form.
- R9: `formSel`=2 is the scalar form: only lane 0 is computed and all higher result bits are zero. `formSel`=3 raises `undefOut`.
- R10: `satFlag` is sticky. When an accepted operation saturates any active lane, `satFlag` becomes 1. Only `satClr` clears it; a clear applies before the same cycle's new saturations.
- R11: `inReady` = !`outValid` || `outReady`. A result appears on the cycle after acceptance and is held stable while `outValid` && !`outReady`.
- R12: After reset `outValid`, `undefOut`, `satFlag` and `resOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation can be taken |
| subSel | input | 1 | 1 = subtract doubled product |
| elemSize | input | 2 | Lane size code (1 = 16, 2 = 32) |
| wideSel | input | 1 | 1 = 128-bit vector, 0 = 64-bit |
| formSel | input | 2 | 0 vector, 1 by-element, 2 scalar |
| laneIdx | input | 3 | Element index for by-element form |
| featEn | input | 1 | Operation enabled |
| satClr | input | 1 | Clears the sticky saturation flag |
| accIn | input | 128 | Accumulator (destination) operand |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| outValid | output | 1 | Result register holds a result |
| outReady | input | 1 | Consumer takes the result |
| resOut | output | 128 | Result register |
| undefOut | output | 1 | Last result was an undefined operation |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
The assertions take for granted that `accIn`, `elemSize`, `formSel`, `wideSel` and `featEn` carry known values in any cycle where an operation is accepted. They also assume that `satClr` is a plain level, with no timing relation to the handshake. The bench changes inputs only on the falling clock edge, so every accepted operation presents one settled operand set. Random stimulus is weighted toward legal sizes and forms, with rare illegal codes and with extreme operands that drive the clamps.

// File: rtl/rdmac_pkg.sv
package rdmac_pkg;
  typedef enum logic [1:0] {
    FORM_VEC  = 2'd0,
    FORM_ELEM = 2'd1,
    FORM_SCAL = 2'd2,
    FORM_RSVD = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_H16 = 2'd1,
    SZ_W32 = 2'd2,
    SZ_D64 = 2'd3
  } size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic illegal;
    logic half16;
    logic wide;
    logic byElem;
    logic scalar;
    logic subOp;
    logic clearSat;
  } strobe_t;
endpackage

// File: rtl/rdmac_lane.sv
module rdmac_lane #(
  parameter int N = 16
) (
  input  logic [N-1:0] accEl,
  input  logic [N-1:0] aEl,
  input  logic [N-1:0] bEl,
  input  logic         subOp,
  output logic [N-1:0] resEl,
  output logic         satEl
);
  localparam int W = 2*N + 2;
  localparam logic signed [W-1:0] RND  = {{(N+2){1'b0}}, 1'b1, {(N-1){1'b0}}};
  localparam logic signed [W-1:0] MAXV = {{(N+3){1'b0}}, {(N-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {{(N+3){1'b1}}, {(N-1){1'b0}}};

  logic signed [2*N-1:0] prod;
  logic signed [W-1:0]   accShift;
  logic signed [W-1:0]   dbl;
  logic signed [W-1:0]   pre;
  logic signed [W-1:0]   shifted;

  always_comb begin
    prod     = $signed(aEl) * $signed(bEl);
    accShift = {{2{accEl[N-1]}}, accEl, {N{1'b0}}};
    dbl      = {prod[2*N-1], prod, 1'b0};
    if (subOp) pre = accShift - dbl + RND;
    else       pre = accShift + dbl + RND;
    shifted  = pre >>> N;
    if (shifted > MAXV) begin
      resEl = MAXV[N-1:0];
      satEl = 1'b1;
    end else if (shifted < MINV) begin
      resEl = MINV[N-1:0];
      satEl = 1'b1;
    end else begin
      resEl = shifted[N-1:0];
      satEl = 1'b0;
    end
  end
endmodule

// File: rtl/rdmac_ctrl.sv
module rdmac_ctrl
  import rdmac_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int L16 = VEC_W / 16,
  localparam int L32 = VEC_W / 32,
  localparam int IDX_W = $clog2(L16)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             outReady,
  output logic             outValid,
  input  logic             subSel,
  input  logic [1:0]       elemSize,
  input  logic             wideSel,
  input  logic [1:0]       formSel,
  input  logic [IDX_W-1:0] laneIdx,
  input  logic             featEn,
  input  logic             satClr,
  output strobe_t          strb
);
  form_e form;
  size_e size;
  logic  sizeOk;
  logic  idxOk;
  logic  fire;
  int    elemCnt;

  always_comb begin
    form   = form_e'(formSel);
    size   = size_e'(elemSize);
    sizeOk = (size == SZ_H16) || (size == SZ_W32);
    if (size == SZ_H16) elemCnt = wideSel ? L16 : L16 / 2;
    else                elemCnt = wideSel ? L32 : L32 / 2;
    idxOk  = int'(laneIdx) < elemCnt;
  end

  assign inReady = !outValid || outReady;
  assign fire    = inValid && inReady;

  always_comb begin
    strb.capture  = fire;
    strb.illegal  = !featEn || !sizeOk || (form == FORM_RSVD) ||
                    ((form == FORM_ELEM) && !idxOk);
    strb.half16   = (size == SZ_H16);
    strb.wide     = wideSel;
    strb.byElem   = (form == FORM_ELEM);
    strb.scalar   = (form == FORM_SCAL);
    strb.subOp    = subSel;
    strb.clearSat = satClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else if (fire) outValid <= 1'b1;
    else if (outReady) outValid <= 1'b0;
  end
endmodule

// File: rtl/rdmac_datapath.sv
module rdmac_datapath
  import rdmac_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int L16 = VEC_W / 16,
  localparam int L32 = VEC_W / 32,
  localparam int IDX_W = $clog2(L16)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] laneIdx,
  input  logic [VEC_W-1:0] accIn,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [VEC_W-1:0] resOut,
  output logic             undefOut,
  output logic             satFlag
);
  logic [15:0]      bSel16;
  logic [31:0]      bSel32;
  logic [IDX_W-2:0] idx32;
  logic [VEC_W-1:0] r16, r32, m16, m32, resNext;
  logic [L16-1:0]   s16, act16;
  logic [L32-1:0]   s32, act32;
  logic             satNext;

  assign idx32  = laneIdx[IDX_W-2:0];
  assign bSel16 = srcB[laneIdx*16 +: 16];
  assign bSel32 = srcB[idx32*32 +: 32];

  for (genvar g = 0; g < L16; g++) begin : g_h16
    rdmac_lane #(.N(16)) u_lane (
      .accEl (accIn[g*16 +: 16]),
      .aEl   (srcA[g*16 +: 16]),
      .bEl   (strb.byElem ? bSel16 : srcB[g*16 +: 16]),
      .subOp (strb.subOp),
      .resEl (r16[g*16 +: 16]),
      .satEl (s16[g])
    );
  end

  for (genvar g = 0; g < L32; g++) begin : g_w32
    rdmac_lane #(.N(32)) u_lane (
      .accEl (accIn[g*32 +: 32]),
      .aEl   (srcA[g*32 +: 32]),
      .bEl   (strb.byElem ? bSel32 : srcB[g*32 +: 32]),
      .subOp (strb.subOp),
      .resEl (r32[g*32 +: 32]),
      .satEl (s32[g])
    );
  end

  // active lanes and masking of inactive ones
  always_comb begin
    for (int i = 0; i < L16; i++) begin
      if (strb.scalar)    act16[i] = (i == 0);
      else if (strb.wide) act16[i] = 1'b1;
      else                act16[i] = (i < L16 / 2);
      m16[i*16 +: 16] = act16[i] ? r16[i*16 +: 16] : 16'd0;
    end
    for (int i = 0; i < L32; i++) begin
      if (strb.scalar)    act32[i] = (i == 0);
      else if (strb.wide) act32[i] = 1'b1;
      else                act32[i] = (i < L32 / 2);
      m32[i*32 +: 32] = act32[i] ? r32[i*32 +: 32] : 32'd0;
    end
    if (strb.illegal) begin
      resNext = accIn;
      satNext = 1'b0;
    end else if (strb.half16) begin
      resNext = m16;
      satNext = |(s16 & act16);
    end else begin
      resNext = m32;
      satNext = |(s32 & act32);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut   <= '0;
      undefOut <= 1'b0;
    end else if (strb.capture) begin
      resOut   <= resNext;
      undefOut <= strb.illegal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) satFlag <= 1'b0;
    else satFlag <= (strb.clearSat ? 1'b0 : satFlag) | (strb.capture & satNext);
  end
endmodule

// File: rtl/rdmac_top.sv
module rdmac_top
  import rdmac_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int IDX_W = $clog2(VEC_W / 16)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             subSel,
  input  logic [1:0]       elemSize,
  input  logic             wideSel,
  input  logic [1:0]       formSel,
  input  logic [IDX_W-1:0] laneIdx,
  input  logic             featEn,
  input  logic             satClr,
  input  logic [VEC_W-1:0] accIn,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic             outValid,
  input  logic             outReady,
  output logic [VEC_W-1:0] resOut,
  output logic             undefOut,
  output logic             satFlag
);
  strobe_t strb;

  rdmac_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .subSel(subSel),
    .elemSize(elemSize), .wideSel(wideSel), .formSel(formSel),
    .laneIdx(laneIdx), .featEn(featEn), .satClr(satClr), .strb(strb)
  );

  rdmac_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .laneIdx(laneIdx),
    .accIn(accIn), .srcA(srcA), .srcB(srcB),
    .resOut(resOut), .undefOut(undefOut), .satFlag(satFlag)
  );
endmodule

// File: rtl/rdmac_check.sv
module rdmac_check #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [1:0]       elemSize,
  input logic             wideSel,
  input logic [1:0]       formSel,
  input logic             featEn,
  input logic             satClr,
  input logic [VEC_W-1:0] accIn,
  input logic [VEC_W-1:0] resOut,
  input logic             undefOut,
  input logic             satFlag
);
  logic fire;
  assign fire = inValid && inReady;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(resOut) && $stable(undefOut));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> outValid);

  assert_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    fire && !featEn |=> undefOut && (resOut == $past(accIn)));

  assert_badsize_R5: assert property (@(posedge clk) disable iff (!rstN)
    fire && (elemSize == 2'd0 || elemSize == 2'd3) |=> undefOut && (resOut == $past(accIn)));

  assert_narrow_R7: assert property (@(posedge clk) disable iff (!rstN)
    fire && featEn && !wideSel && formSel == 2'd0 && (elemSize == 2'd1 || elemSize == 2'd2)
    |=> !undefOut && (resOut[VEC_W-1:VEC_W/2] == '0));

  assert_scalar_R9: assert property (@(posedge clk) disable iff (!rstN)
    fire && featEn && formSel == 2'd2 && elemSize == 2'd2 |=> resOut[VEC_W-1:32] == '0);

  assert_rsvdform_R9: assert property (@(posedge clk) disable iff (!rstN)
    fire && formSel == 2'd3 |=> undefOut);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    satFlag && !satClr |=> satFlag);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    satClr && !fire |=> !satFlag);

  assert_undef_nosat_R6: assert property (@(posedge clk) disable iff (!rstN)
    fire && !featEn && !satFlag |=> !satFlag);
endmodule

bind rdmac_top rdmac_check #(.VEC_W(VEC_W)) u_check (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .elemSize(elemSize),
  .wideSel(wideSel), .formSel(formSel), .featEn(featEn), .satClr(satClr),
  .accIn(accIn), .resOut(resOut), .undefOut(undefOut), .satFlag(satFlag)
);

// File: tb/rdmac_top_bench.sv
module rdmac_top_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0, inReady;
  logic         subSel = 1'b0;
  logic [1:0]   elemSize = 2'd1;
  logic         wideSel = 1'b1;
  logic [1:0]   formSel = 2'd0;
  logic [2:0]   laneIdx = 3'd0;
  logic         featEn = 1'b1;
  logic         satClr = 1'b0;
  logic [127:0] accIn = '0, srcA = '0, srcB = '0;
  logic         outValid, outReady = 1'b1;
  logic [127:0] resOut;
  logic         undefOut, satFlag;

  int  nChecks = 0;
  int  nFail = 0;
  bit  expSat = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  rdmac_top u_rdmac_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .subSel(subSel), .elemSize(elemSize), .wideSel(wideSel), .formSel(formSel),
    .laneIdx(laneIdx), .featEn(featEn), .satClr(satClr), .accIn(accIn),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .outReady(outReady),
    .resOut(resOut), .undefOut(undefOut), .satFlag(satFlag)
  );

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic signed [67:0] getEl(input logic [127:0] v, input int i, input int n);
    if (n == 16) return 68'($signed(v[i*16 +: 16]));
    return 68'($signed(v[i*32 +: 32]));
  endfunction

  // reference model written from the requirements
  function automatic void refOp(input logic [127:0] acc, input logic [127:0] a,
      input logic [127:0] b, input bit sub, input logic [1:0] sz, input bit wide,
      input logic [1:0] form, input logic [2:0] idx, input bit en,
      output logic [127:0] res, output bit sat, output bit undef);
    int n, cnt, lanes;
    logic signed [67:0] av, bv, cv, t, mx, mn;
    n = (sz == 2'd1) ? 16 : 32;
    cnt = wide ? 128 / n : 64 / n;
    lanes = (form == 2'd2) ? 1 : cnt;
    undef = !en || sz == 2'd0 || sz == 2'd3 || form == 2'd3 ||
            (form == 2'd1 && int'(idx) >= cnt);
    res = '0;
    sat = 1'b0;
    if (undef) begin
      res = acc;
      return;
    end
    mx = (68'sd1 <<< (n - 1)) - 68'sd1;
    mn = -(68'sd1 <<< (n - 1));
    for (int i = 0; i < lanes; i++) begin
      cv = getEl(acc, i, n);
      av = getEl(a, i, n);
      bv = (form == 2'd1) ? getEl(b, int'(idx), n) : getEl(b, i, n);
      t = (cv <<< n) + (sub ? -(68'sd2 * av * bv) : (68'sd2 * av * bv)) + (68'sd1 <<< (n - 1));
      t = t >>> n;
      if (t > mx) begin t = mx; sat = 1'b1; end
      else if (t < mn) begin t = mn; sat = 1'b1; end
      if (n == 16) res[i*16 +: 16] = t[15:0];
      else         res[i*32 +: 32] = t[31:0];
    end
  endfunction

  task automatic drive(input bit sub, input logic [1:0] sz, input bit wide,
      input logic [1:0] form, input logic [2:0] idx, input bit en,
      input logic [127:0] acc, input logic [127:0] a, input logic [127:0] b);
    subSel = sub; elemSize = sz; wideSel = wide; formSel = form;
    laneIdx = idx; featEn = en; accIn = acc; srcA = a; srcB = b;
  endtask

  task automatic issue(input string tag, input bit sub, input logic [1:0] sz,
      input bit wide, input logic [1:0] form, input logic [2:0] idx, input bit en,
      input logic [127:0] acc, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] eRes;
    bit eSat, eUndef;
    @(negedge clk);
    drive(sub, sz, wide, form, idx, en, acc, a, b);
    inValid = 1'b1;
    outReady = 1'b1;
    refOp(acc, a, b, sub, sz, wide, form, idx, en, eRes, eSat, eUndef);
    @(negedge clk);
    inValid = 1'b0;
    expSat = expSat | eSat;
    chk({tag, " R11 valid"}, {127'd0, outValid}, 128'd1);
    chk({tag, " result"}, resOut, eRes);
    chk({tag, " undef"}, {127'd0, undefOut}, {127'd0, eUndef});
    chk({tag, " R10 sat"}, {127'd0, satFlag}, {127'd0, expSat});
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R11: watchdog got hung expected completion");
    finishRun();
  end

  initial begin
    logic [127:0] rA, rB, rC, eRes, held;
    bit eSat, eUndef;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 outValid", {127'd0, outValid}, '0);
    chk("R12 undef", {127'd0, undefOut}, '0);
    chk("R12 sat", {127'd0, satFlag}, '0);
    chk("R12 res", resOut, '0);
    rstN = 1'b1;

    // R1 plain accumulate, 16-bit and 32-bit
    issue("R1 h16", 0, 2'd1, 1, 2'd0, 3'd0, 1, {8{16'h0123}}, {8{16'h4000}}, {4{16'h2000, 16'hC000}});
    issue("R1 w32", 0, 2'd2, 1, 2'd0, 3'd0, 1, {4{32'h1234_5678}}, {4{32'h0001_8000}}, {4{32'h7FFF_0001}});
    // R2 subtract
    issue("R2 h16", 1, 2'd1, 1, 2'd0, 3'd0, 1, {8{16'h0100}}, {8{16'h3000}}, {8{16'h0400}});
    // R3 positive clamp
    issue("R3 max16", 0, 2'd1, 1, 2'd0, 3'd0, 1, '0, {8{16'h8000}}, {8{16'h8000}});
    // R10 sticky hold and clear
    @(negedge clk);
    chk("R10 held", {127'd0, satFlag}, 128'd1);
    satClr = 1'b1;
    @(negedge clk);
    satClr = 1'b0;
    expSat = 1'b0;
    chk("R10 cleared", {127'd0, satFlag}, '0);
    // R4 negative clamp
    issue("R4 min32", 1, 2'd2, 1, 2'd0, 3'd0, 1, {4{32'h8000_0000}}, {4{32'h8000_0000}}, {4{32'h8000_0000}});
    @(negedge clk);
    satClr = 1'b1;
    @(negedge clk);
    satClr = 1'b0;
    expSat = 1'b0;
    // R5 bad size codes, R6 disabled: sat must stay clear
    issue("R5 size0", 0, 2'd0, 1, 2'd0, 3'd0, 1, {8{16'hABCD}}, {8{16'h8000}}, {8{16'h8000}});
    issue("R5 size3", 0, 2'd3, 1, 2'd0, 3'd0, 1, {4{32'h1357_9BDF}}, {8{16'h8000}}, {8{16'h8000}});
    issue("R6 disabled", 0, 2'd1, 1, 2'd0, 3'd0, 0, {8{16'h5A5A}}, {8{16'h8000}}, {8{16'h8000}});
    // R7 narrow width
    issue("R7 narrow16", 0, 2'd1, 0, 2'd0, 3'd0, 1, {8{16'h7777}}, {8{16'h1111}}, {8{16'h2222}});
    issue("R7 narrow32", 1, 2'd2, 0, 2'd0, 3'd0, 1, {4{32'h7777_0000}}, {4{32'h1111_1111}}, {4{32'h2222_2222}});
    // R8 by-element
    issue("R8 elem5", 0, 2'd1, 1, 2'd1, 3'd5, 1, {8{16'h0010}}, {16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5000, 16'h6000, 16'h7000, 16'h0800},
          {16'h0001, 16'h0002, 16'h7ABC, 16'h0004, 16'h0005, 16'h0006, 16'h0007, 16'h0008});
    issue("R8 idx4 narrow", 0, 2'd1, 0, 2'd1, 3'd4, 1, {8{16'h0042}}, {8{16'h1000}}, {8{16'h1000}});
    issue("R8 idx2 w32 narrow", 0, 2'd2, 0, 2'd1, 3'd2, 1, {4{32'h0042_0000}}, {8{16'h1000}}, {8{16'h1000}});
    issue("R8 idx3 w32", 1, 2'd2, 1, 2'd1, 3'd3, 1, {4{32'h0000_1000}}, {4{32'h4000_0000}}, {32'h2000_0000, 96'd0});
    // R9 scalar and reserved form
    issue("R9 scalar16", 0, 2'd1, 1, 2'd2, 3'd0, 1, {8{16'h0F0F}}, {8{16'h2345}}, {8{16'h6789}});
    issue("R9 scalar32", 0, 2'd2, 0, 2'd2, 3'd0, 1, {4{32'h0F0F_0F0F}}, {4{32'h2345_6789}}, {4{32'h6789_ABCD}});
    issue("R9 rsvd", 0, 2'd1, 1, 2'd3, 3'd0, 1, {8{16'h3C3C}}, {8{16'h1000}}, {8{16'h1000}});

    // R11 backpressure
    @(negedge clk);
    drive(0, 2'd1, 1, 2'd0, 3'd0, 1, {8{16'h0001}}, {8{16'h0100}}, {8{16'h0100}});
    refOp(accIn, srcA, srcB, 0, 2'd1, 1, 2'd0, 3'd0, 1, held, eSat, eUndef);
    inValid = 1'b1;
    outReady = 1'b0;
    @(negedge clk);
    chk("R11 stalled ready", {127'd0, inReady}, '0);
    drive(1, 2'd2, 1, 2'd0, 3'd0, 1, {4{32'h0000_0002}}, {4{32'h0100_0000}}, {4{32'h0100_0000}});
    refOp(accIn, srcA, srcB, 1, 2'd2, 1, 2'd0, 3'd0, 1, eRes, eSat, eUndef);
    @(negedge clk);
    chk("R11 held result", resOut, held);
    chk("R11 held valid", {127'd0, outValid}, 128'd1);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R11 next result", resOut, eRes);
    @(negedge clk);
    chk("R11 drained", {127'd0, outValid}, '0);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      int r;
      logic [1:0] sz, fm;
      r = int'($urandom % 8);
      sz = (r < 3) ? 2'd1 : (r < 6) ? 2'd2 : (r == 6) ? 2'd0 : 2'd3;
      r = int'($urandom % 10);
      fm = (r < 4) ? 2'd0 : (r < 7) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
      rA = {$urandom, $urandom, $urandom, $urandom};
      rB = {$urandom, $urandom, $urandom, $urandom};
      rC = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 4 == 0) begin
        rA = {8{16'h8000}};
        rB = ($urandom % 2 == 1) ? {8{16'h8000}} : {8{16'h7FFF}};
      end
      if (k % 50 == 49) begin
        @(negedge clk);
        satClr = 1'b1;
        @(negedge clk);
        satClr = 1'b0;
        expSat = 1'b0;
      end
      // R1 (add) and R2 (subtract) random mix
      issue((k % 2 == 0) ? "R1 rnd" : "R2 rnd", k % 2 == 1, sz, $urandom % 2 == 1, fm,
            3'($urandom % 8), ($urandom % 10) != 0, rC, rA, rB);
    end
    finishRun();
  end
endmodule